// File: doc/BRIEF.md
# Serial Command Frame Front End

This block receives fixed-length command frames on a four-wire serial link and turns each complete frame into a one-cycle command strobe carrying an opcode, an address and a data word. The serial clock, select and data inputs are sampled by the block's own system clock (they are assumed already synchronised), so all internal state lives in one clock domain. A frame is accepted only when chip-select returns high after exactly the right number of serial clock edges; anything else is dropped without effect.

The serial output normally repeats the input stream one frame length later, so several of these front ends can be chained on one select line. Two readback opcodes replace part of that echo: the value returned by the surrounding logic (a stored word, or a narrower wiper position) is loaded into the low part of the frame register, and the next frame clocks it out. A busy-lock input freezes the interface while the surrounding logic is occupied.

Top module: `serial_cmd_frontend`

## Requirements
- R1: A frame is 24 bits sent MSB first; on dispatch, bits 23:20 appear on `cmd_op_o`, bits 19:16 on `cmd_addr_o` and bits 15:0 on `cmd_data_o`, and these fields hold until the next dispatch.
- R2: A bit of `sdi_i` is taken only on a rising edge of `sclk_i` seen while `csn_i` is low; rising edges seen while `csn_i` is high change nothing.
- R3: Dispatch happens only when `csn_i` rises: `cmd_vld_o` is high for exactly one clock, in the clock after the rise is sampled, and never while bits are still arriving.
- R4: A frame whose count of accepted edges differs from 24 raises no strobe and triggers no readback load.
- R5: A frame with opcode 0 raises no strobe.
- R6: `sdo_o` presents, just before each accepted serial edge, the bit that was accepted 24 edges earlier (0 after reset).
- R7: After a dispatched opcode 9, the 16-bit `rd_data_i` present during the strobe is loaded so that the next frame's output bits 8 to 23 carry it MSB first; output bits 0 to 7 carry the readback frame's own opcode and address.
- R8: After a dispatched opcode 10, only `rd_data_i[9:0]` is returned in that same position, with the upper 6 bits of the 16-bit field forced to zero.
- R9: While `lock_i` is high, serial edges and chip-select rises are ignored: no strobe, and the echoed stream is unchanged.
- R10: After reset, `cmd_vld_o`, `sdo_o` and all command fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Busy lock; freezes the serial interface while high |
| csn_i | input | 1 | Chip-select, active low |
| sclk_i | input | 1 | Serial clock, bits taken on its rising edge |
| sdi_i | input | 1 | Serial data in, MSB first |
| sdo_o | output | 1 | Serial data out: delayed echo or readback value |
| rd_data_i | input | 16 | Readback value supplied for the address on `cmd_addr_o` during the strobe |
| cmd_vld_o | output | 1 | One-cycle command strobe |
| cmd_op_o | output | 4 | Opcode of the last dispatched frame |
| cmd_addr_o | output | 4 | Address of the last dispatched frame |
| cmd_data_o | output | 16 | Data word of the last dispatched frame |

## Verification
On every cycle the assertions check that a strobe lasts a single clock, follows a sampled chip-select rise with the lock released, never carries the do-nothing opcode, and never appears in the clock after the lock was high. Whether the right fields are dispatched, whether short or long frames are dropped, and whether the output stream carries the echo or the masked readback value can only be shown by the bench's frame sweep, which compares every output bit against a frame-level model built from the requirements.

// File: rtl/serial_cmd_pkg.sv
package serial_cmd_pkg;
    localparam int OP_W = 4;
    typedef enum logic [OP_W-1:0] {
        OP_IDLE     = 4'd0,
        OP_RD_STORE = 4'd9,
        OP_RD_WIPER = 4'd10
    } special_op_e;
endpackage

// File: rtl/sce_edge_det.sv
// Registers a vector of sampled inputs so the parent can see edges.
module sce_edge_det #(
    parameter int          W       = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] x_i,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = x_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    assign prev_o = prev_q;
endmodule

// File: rtl/sce_bit_counter.sv
// Saturating count of accepted serial edges within one frame.
module sce_bit_counter #(
    parameter int FRAME_W = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic full_o
);
    localparam int CNT_W = $clog2(FRAME_W) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_EXACT = CNT_W'(FRAME_W);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                        cnt_d = '0;
        else if (inc_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign full_o = (cnt_q == CNT_EXACT);
endmodule

// File: rtl/sce_shift_reg.sv
// Frame register: shifts in MSB first, top bit drives the output, low
// field can be overwritten with a readback value.
module sce_shift_reg #(
    parameter int FRAME_W = 24,
    parameter int DATA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_i,
    input  logic               bit_i,
    input  logic               load_i,
    input  logic [DATA_W-1:0]  load_val_i,
    output logic [FRAME_W-1:0] q_o
);
    logic [FRAME_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i)       sh_d[DATA_W-1:0] = load_val_i;
        else if (shift_i) sh_d = {sh_q[FRAME_W-2:0], bit_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q;
endmodule

// File: rtl/serial_cmd_frontend.sv
module serial_cmd_frontend
    import serial_cmd_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16,
    parameter int WIPER_W = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lock_i,
    input  logic                          csn_i,
    input  logic                          sclk_i,
    input  logic                          sdi_i,
    output logic                          sdo_o,
    input  logic [DATA_W-1:0]             rd_data_i,
    output logic                          cmd_vld_o,
    output logic [serial_cmd_pkg::OP_W-1:0] cmd_op_o,
    output logic [ADDR_W-1:0]             cmd_addr_o,
    output logic [DATA_W-1:0]             cmd_data_o
);
    localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
    localparam int OP_LSB  = ADDR_W + DATA_W;

    typedef struct packed {
        logic              vld;
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    // Edge detection on chip-select (bit 1) and serial clock (bit 0)
    logic [1:0] pins_prev;
    sce_edge_det #(.W(2), .RST_VAL(2'b10)) u_edges (
        .clk    (clk),
        .rst_n  (rst_n),
        .x_i    ({csn_i, sclk_i}),
        .prev_o (pins_prev)
    );

    logic active, cs_rise, cs_fall, bit_take;
    assign active   = !lock_i;
    assign cs_rise  = active &&  csn_i && !pins_prev[1];
    assign cs_fall  = active && !csn_i &&  pins_prev[1];
    assign bit_take = active && !csn_i && sclk_i && !pins_prev[0];

    logic frame_full;
    sce_bit_counter #(.FRAME_W(FRAME_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cs_rise || cs_fall),
        .inc_i  (bit_take),
        .full_o (frame_full)
    );

    // Readback load happens in the clock after the strobe
    logic              rb_load;
    logic [DATA_W-1:0] rb_val;
    always_comb begin
        rb_load = cmd_q.vld &&
                  (cmd_q.op == OP_RD_STORE || cmd_q.op == OP_RD_WIPER);
        rb_val  = rd_data_i;
        if (cmd_q.op == OP_RD_WIPER)
            rb_val = {{(DATA_W-WIPER_W){1'b0}}, rd_data_i[WIPER_W-1:0]};
    end

    logic [FRAME_W-1:0] frame_q;
    sce_shift_reg #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_i    (bit_take),
        .bit_i      (sdi_i),
        .load_i     (rb_load),
        .load_val_i (rb_val),
        .q_o        (frame_q)
    );

    logic [OP_W-1:0] fr_op;
    assign fr_op = frame_q[OP_LSB +: OP_W];

    always_comb begin
        cmd_d     = cmd_q;
        cmd_d.vld = 1'b0;
        if (cs_rise && frame_full && fr_op != OP_IDLE) begin
            cmd_d.vld  = 1'b1;
            cmd_d.op   = fr_op;
            cmd_d.addr = frame_q[DATA_W +: ADDR_W];
            cmd_d.data = frame_q[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cmd_q <= '0;
        else        cmd_q <= cmd_d;
    end

    assign sdo_o      = frame_q[FRAME_W-1];
    assign cmd_vld_o  = cmd_q.vld;
    assign cmd_op_o   = cmd_q.op;
    assign cmd_addr_o = cmd_q.addr;
    assign cmd_data_o = cmd_q.data;
endmodule

// File: rtl/serial_cmd_frontend_chk.sv
module serial_cmd_frontend_chk #(
    parameter int OPW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           lock_i,
    input logic           csn_i,
    input logic           cmd_vld_o,
    input logic [OPW-1:0] cmd_op_o
);
    // R3: strobe lasts exactly one clock
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |=> !cmd_vld_o);

    // R3: strobe only after a sampled chip-select rise with lock released
    p_after_cs_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> ($past(csn_i) && !$past(csn_i, 2) && !$past(lock_i)));

    // R5: the do-nothing opcode never strobes
    p_no_idle_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_vld_o |-> (cmd_op_o != '0));

    // R9: lock high blocks a strobe in the following clock
    p_lock_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> !cmd_vld_o);
endmodule

bind serial_cmd_frontend serial_cmd_frontend_chk #(.OPW(serial_cmd_pkg::OP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_i    (lock_i),
    .csn_i     (csn_i),
    .cmd_vld_o (cmd_vld_o),
    .cmd_op_o  (cmd_op_o)
);

// File: tb/serial_cmd_frontend_bench.sv
module serial_cmd_frontend_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lock_i = 1'b0;
    logic        csn_i = 1'b1;
    logic        sclk_i = 1'b0;
    logic        sdi_i = 1'b0;
    logic        sdo_o;
    logic [15:0] rd_data_i;
    logic        cmd_vld_o;
    logic [3:0]  cmd_op_o;
    logic [3:0]  cmd_addr_o;
    logic [15:0] cmd_data_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    serial_cmd_frontend u_serial_cmd_frontend (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .csn_i(csn_i),
        .sclk_i(sclk_i), .sdi_i(sdi_i), .sdo_o(sdo_o), .rd_data_i(rd_data_i),
        .cmd_vld_o(cmd_vld_o), .cmd_op_o(cmd_op_o),
        .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o)
    );

    // Readback source: upper bits set so the wiper mask is visible
    function automatic logic [15:0] rb_src(input logic [3:0] a);
        return {4'hF, a, ~a, a};
    endfunction
    assign rd_data_i = rb_src(cmd_addr_o);

    // Strobe monitor, sampled away from the active edge
    int          stb_cnt = 0;
    logic [3:0]  stb_op;
    logic [3:0]  stb_addr;
    logic [15:0] stb_data;
    always @(negedge clk) if (cmd_vld_o) begin
        stb_cnt++;
        stb_op = cmd_op_o; stb_addr = cmd_addr_o; stb_data = cmd_data_o;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    logic [23:0] model = '0;

    task automatic frame(input logic [23:0] w, input int nbits, input bit locked);
        logic [31:0] got;
        logic [31:0] exp;
        bit          echo_ok;
        bit          want;
        logic [3:0]  op;
        echo_ok = 1'b1; got = '0; exp = '0;
        op = w[23:20];
        lock_i = locked;
        tick(2);
        csn_i = 1'b0;
        stb_cnt = 0;
        tick(2);
        for (int i = 0; i < nbits; i++) begin
            logic b;
            b = (i < 24) ? w[23-i] : 1'b1;
            sdi_i = b;
            tick(2);
            got = {got[30:0], sdo_o};
            exp = {exp[30:0], model[23]};
            if (sdo_o !== model[23]) echo_ok = 1'b0;
            if (!locked) model = {model[22:0], b};
            sclk_i = 1'b1;
            tick(2);
            sclk_i = 1'b0;
            tick(2);
        end
        // R3: nothing dispatched while bits arrive
        check(stb_cnt == 0, "R3 no strobe mid-frame", stb_cnt, 0);
        // R6/R7/R8/R9: output stream equals model (echo or readback)
        check(echo_ok, locked ? "R9 locked stream unchanged" : "R6/R7/R8 sdo stream", got, exp);
        csn_i = 1'b1;
        tick(6);
        want = !locked && nbits == 24 && op != 4'd0;
        if (!locked && nbits == 24 && op == 4'd0)
            check(stb_cnt == 0, "R5 idle opcode no strobe", stb_cnt, 0);
        else if (nbits != 24)
            check(stb_cnt == 0, "R4 bad length dropped", stb_cnt, 0);
        else if (locked)
            check(stb_cnt == 0, "R9 locked no strobe", stb_cnt, 0);
        else begin
            check(stb_cnt == 1, "R3 single strobe", stb_cnt, 1);
            check({stb_op, stb_addr, stb_data} === w, "R1 fields", {stb_op, stb_addr, stb_data}, w);
        end
        if (want && op == 4'd9)  model[15:0] = rb_src(w[19:16]);
        if (want && op == 4'd10) model[15:0] = rb_src(w[19:16]) & 16'h03FF;
        lock_i = 1'b0;
        tick(2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);
        // R10: reset state
        check(cmd_vld_o == 0 && sdo_o == 0 && cmd_op_o == 0 && cmd_addr_o == 0 && cmd_data_o == 0,
              "R10 reset state", {cmd_vld_o, sdo_o, cmd_op_o, cmd_addr_o, cmd_data_o}, 0);
        // R2: serial edges while deselected change nothing
        for (int i = 0; i < 5; i++) begin
            sdi_i = 1'b1; sclk_i = 1'b1; tick(2); sclk_i = 1'b0; tick(2);
        end
        check(sdo_o == 0 && stb_cnt == 0, "R2 edges with select high ignored", sdo_o, 0);
        // Sweep every opcode over several addresses (R1, R5, R6, R7, R8)
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a += 5) begin
                logic [15:0] d;
                d = 16'(op * 16'h1357) ^ 16'(a * 16'h0F0F);
                frame({4'(op), 4'(a), d}, 24, 1'b0);
            end
        end
        // R4: short and long frames, including a readback opcode
        frame({4'd11, 4'd1, 16'hBEEF}, 23, 1'b0);
        frame({4'd9,  4'd2, 16'h1234}, 25, 1'b0);
        frame({4'd10, 4'd3, 16'h0000}, 8, 1'b0);
        frame({4'd11, 4'd4, 16'h5A5A}, 24, 1'b0);
        // R9: locked frames, including a readback request
        frame({4'd11, 4'd6, 16'hFFFF}, 24, 1'b1);
        frame({4'd10, 4'd7, 16'h0001}, 24, 1'b1);
        // R7 / R8 back to back, then a plain frame to flush the last value
        frame({4'd9,  4'd12, 16'h0000}, 24, 1'b0);
        frame({4'd10, 4'd15, 16'h0000}, 24, 1'b0);
        frame({4'd0,  4'd0,  16'h0000}, 24, 1'b0);
        frame({4'd14, 4'd1,  16'hC3C3}, 24, 1'b0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule